// File: doc/BRIEF.md
# Supply Supervisor with Watchdog Reset

This block produces the single active-low reset for a processor. It uses two fault sources. The first is a digital flag that reports the supply is below its threshold. The second is a watchdog that the processor must service by changing the level of a strobe input. When either fault occurs, reset is driven low. Reset then stays low for a fixed number of clock cycles after the fault clears, so the processor always restarts from a known state after a settled period.

The flag input and the strobe input each pass through a two-flop synchronizer. A rising or a falling strobe transition restarts the watchdog count. The watchdog counter stays at zero while reset is asserted, and it starts counting only once reset releases. A third input reports that the strobe pin is undriven; while it is set, the watchdog is switched off. A status output records which fault started the most recent reset pulse. The watchdog timeout and the reset length are parameters counted in clock cycles.

Top module: `supply_guard`

## Requirements
- R1: While the synchronized undervoltage flag is high, `rst_out_n` is 0. The flag reaches the reset logic two clock cycles after `uv_in`.
- R2: When `uv_in` falls, and no other fault occurs, `rst_out_n` returns to 1 at the RST_PERIOD+2-th rising clock edge after the fall.
- R3: A change of `wdi_in` in either direction restarts the watchdog. Strobe changes spaced fewer than WD_TIMEOUT-4 cycles apart never cause a reset.
- R4: After reset releases, if `wdi_in` does not change, `rst_out_n` stays 1 for exactly WD_TIMEOUT cycles. It then goes 0 for exactly RST_PERIOD cycles.
- R5: The watchdog counter is held at zero while `rst_out_n` is 0. Each high window that follows a reset therefore lasts the full WD_TIMEOUT cycles.
- R6: While `wdi_float` is 1, the watchdog never asserts reset, however long the strobe stays unchanged.
- R7: A `wdi_in` pulse that lasts a single clock cycle is detected as a service event.
- R8: If `uv_in` rises again while reset is still active, the reset period restarts. Release then comes RST_PERIOD+2 edges after the last fall of `uv_in`.
- R9: While `rst_n` is 0, `rst_out_n` is 0. After `rst_n` releases, `rst_out_n` stays 0 for RST_PERIOD rising edges.
- R10: `cause_wdog` is 1 when the current or last reset pulse began with a watchdog timeout. It is 0 when the pulse began with undervoltage or with power-on. The value is latched when the pulse starts and does not change until the next pulse starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the block itself (power-on) |
| uv_in | input | 1 | Supply-below-threshold flag, asynchronous |
| wdi_in | input | 1 | Watchdog strobe, asynchronous |
| wdi_float | input | 1 | 1 when the strobe pin is undriven, which disables the watchdog |
| rst_out_n | output | 1 | Active-low reset to the processor |
| cause_wdog | output | 1 | 1 when the last reset pulse came from a watchdog timeout |

## Verification
The assertions assume that `uv_in`, `wdi_in` and `wdi_float` change only between clock edges. They also assume that `wdi_float` is held steady across a whole reset pulse. The bench drives every input at the falling clock edge and changes `wdi_float` only while reset is high and the watchdog has time to spare. Random strobe gaps are drawn from the range that must not trip the timeout, so every random run has one expected outcome: no reset.

// File: rtl/supply_guard_pkg.sv
// Package: shared types for the supply supervisor.
package supply_guard_pkg;
    // Source that started the current or last reset pulse.
    typedef enum logic {
        CAUSE_SUPPLY = 1'b0,
        CAUSE_WDOG   = 1'b1
    } rst_cause_e;
endpackage

// File: rtl/sg_sync.sv
// Module: sg_sync
// Multi-bit, multi-stage synchronizer. Each bit passes through its own chain
// of flops.
// Assumes: the bits are unrelated; reset clears every stage to 0.
module sg_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    // First stage samples the asynchronous input.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= d;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            // Each later stage re-samples the stage before it.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= '0;
                else        chain[s] <= chain[s-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sg_watchdog.sv
// Module: sg_watchdog
// Watchdog timer. Either edge of the synchronized strobe clears it. It raises
// a one-cycle expire pulse when WD_TIMEOUT cycles pass with no edge.
// Assumes: strobe_s and off_s are already synchronous; hold is the reset state.
module sg_watchdog #(
    parameter int WD_TIMEOUT = 40,
    localparam int CW = $clog2(WD_TIMEOUT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strobe_s,
    input  logic          off_s,
    input  logic          hold,
    output logic          expire,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] LAST = CW'(WD_TIMEOUT - 1);

    logic strobe_d;
    logic edge_seen;

    // Keep the previous strobe sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_d <= 1'b0;
        else        strobe_d <= strobe_s;
    end

    assign edge_seen = strobe_s ^ strobe_d;
    assign expire    = !hold && !off_s && !edge_seen && (count == LAST);

    // Count idle cycles. Clear on service, hold, disable or expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)                                      count <= '0;
        else if (hold || off_s || edge_seen || expire)   count <= '0;
        else                                             count <= count + 1'b1;
    end
endmodule

// File: rtl/sg_pulse_timer.sv
// Module: sg_pulse_timer
// Reset-pulse stretcher. It holds reset active while undervoltage is present
// and for RST_PERIOD cycles after the last fault. It latches the fault cause
// when a pulse starts.
// Assumes: wd_expire never occurs while active (the watchdog is held then).
module sg_pulse_timer
    import supply_guard_pkg::*;
#(
    parameter int RST_PERIOD = 16,
    localparam int PW = $clog2(RST_PERIOD + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          uv_s,
    input  logic          wd_expire,
    output logic          active,
    output rst_cause_e    cause,
    output logic [PW-1:0] count
);
    localparam logic [PW-1:0] LAST = PW'(RST_PERIOD - 1);

    // Start, restart or release the pulse and latch its cause at the start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b1;
            count  <= '0;
            cause  <= CAUSE_SUPPLY;
        end else if (uv_s) begin
            if (!active) cause <= CAUSE_SUPPLY;
            active <= 1'b1;
            count  <= '0;
        end else if (wd_expire) begin
            if (!active) cause <= CAUSE_WDOG;
            active <= 1'b1;
            count  <= '0;
        end else if (active) begin
            if (count == LAST) begin
                active <= 1'b0;
                count  <= '0;
            end else begin
                count  <= count + 1'b1;
            end
        end
    end
endmodule

// File: rtl/supply_guard.sv
// Module: supply_guard (top)
// Supply supervisor with a watchdog that drives one active-low processor
// reset. It synchronizes the asynchronous inputs, runs the watchdog and
// stretches each fault into a fixed-length reset pulse.
// Assumes: rst_n is a synchronous active-low power-on reset.
module supply_guard
    import supply_guard_pkg::*;
#(
    parameter int WD_TIMEOUT  = 40,
    parameter int RST_PERIOD  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic uv_in,
    input  logic wdi_in,
    input  logic wdi_float,
    output logic rst_out_n,
    output logic cause_wdog
);
    localparam int CW = $clog2(WD_TIMEOUT + 1);
    localparam int PW = $clog2(RST_PERIOD + 1);

    logic [2:0]    sync_q;
    logic          uv_s;
    logic          wdi_s;
    logic          wdi_float_s;
    logic          wd_expire;
    logic          rst_active;
    logic [CW-1:0] wd_count;
    logic [PW-1:0] rp_count;
    rst_cause_e    cause;

    sg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({wdi_float, wdi_in, uv_in}),
        .q     (sync_q)
    );

    assign uv_s        = sync_q[0];
    assign wdi_s       = sync_q[1];
    assign wdi_float_s = sync_q[2];

    sg_watchdog #(.WD_TIMEOUT(WD_TIMEOUT)) u_wdog (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_s (wdi_s),
        .off_s    (wdi_float_s),
        .hold     (rst_active),
        .expire   (wd_expire),
        .count    (wd_count)
    );

    sg_pulse_timer #(.RST_PERIOD(RST_PERIOD)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .uv_s      (uv_s),
        .wd_expire (wd_expire),
        .active    (rst_active),
        .cause     (cause),
        .count     (rp_count)
    );

    assign rst_out_n  = !rst_active;
    assign cause_wdog = (cause == CAUSE_WDOG);
endmodule

// File: rtl/supply_guard_chk.sv
// Module: supply_guard_chk
// Assertion checker bound to supply_guard. It observes the synchronized
// inputs, both counters and the outputs.
// Assumes: wdi_float stays steady across each reset pulse.
module supply_guard_chk #(
    parameter int WD_TIMEOUT = 40,
    parameter int RST_PERIOD = 16,
    localparam int CW = $clog2(WD_TIMEOUT + 1),
    localparam int PW = $clog2(RST_PERIOD + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          uv_s,
    input logic          wdi_float_s,
    input logic [CW-1:0] wd_count,
    input logic [PW-1:0] rp_count,
    input logic          rst_out_n,
    input logic          cause_wdog
);
    AST_UV_FORCES_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        uv_s |=> !rst_out_n); // R1
    AST_PERIOD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        rp_count < PW'(RST_PERIOD)); // R2
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        wd_count < CW'(WD_TIMEOUT)); // R4
    AST_WDOG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_out_n && $past(!rst_out_n)) |-> (wd_count == '0)); // R5
    AST_FLOAT_NO_WDOG: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rst_out_n) && $past(wdi_float_s)) |-> !cause_wdog); // R6
    AST_UV_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rst_out_n) && $past(uv_s)) |-> !cause_wdog); // R10
    AST_CAUSE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_out_n && $past(!rst_out_n)) |-> $stable(cause_wdog)); // R10
endmodule

bind supply_guard supply_guard_chk #(
    .WD_TIMEOUT (WD_TIMEOUT),
    .RST_PERIOD (RST_PERIOD)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .uv_s        (uv_s),
    .wdi_float_s (wdi_float_s),
    .wd_count    (wd_count),
    .rp_count    (rp_count),
    .rst_out_n   (rst_out_n),
    .cause_wdog  (cause_wdog)
);

// File: tb/supply_guard_test.sv
// Bench: supply_guard_test. Directed corner cases plus seeded random strobe gaps.
module supply_guard_test;
    localparam int T = 40;
    localparam int P = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic uv_in = 1'b0;
    logic wdi_in = 1'b0;
    logic wdi_float = 1'b1;
    logic rst_out_n;
    logic cause_wdog;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    supply_guard #(.WD_TIMEOUT(T), .RST_PERIOD(P)) uut (
        .clk(clk), .rst_n(rst_n), .uv_in(uv_in), .wdi_in(wdi_in),
        .wdi_float(wdi_float), .rst_out_n(rst_out_n), .cause_wdog(cause_wdog)
    );

    always #5 clk = ~clk;

    // Expected durations, derived from the requirements.
    function automatic int exp_uv_release();  return P + 2; endfunction
    function automatic int exp_wd_high();     return T;     endfunction
    function automatic int exp_pulse();       return P;     endfunction
    function automatic bit exp_trip(int gap); return gap >= T - 4; endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Count rising edges until rst_out_n reaches the level given.
    task automatic edges_until(input logic lvl, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (rst_out_n != lvl && n < 1000);
    endtask

    // Run n cycles and count the cycles in which reset is low.
    task automatic idle_lows(input int n, output int lows);
        lows = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (!rst_out_n) lows++;
        end
    endtask

    initial begin
        int n;
        int lows;
        void'($urandom(32'd2024));
        cyc(3);
        check("R9 reset held", int'(rst_out_n), 0);
        check("R10 power-on cause", int'(cause_wdog), 0);
        rst_n = 1'b1;
        edges_until(1'b1, n);
        check("R9 power-on length", n, exp_pulse());

        // Undervoltage pulse, watchdog off.
        uv_in = 1'b1;
        cyc(4);
        check("R1 uv asserts reset", int'(rst_out_n), 0);
        check("R10 uv cause", int'(cause_wdog), 0);
        uv_in = 1'b0;
        edges_until(1'b1, n);
        check("R2 release after uv", n, exp_uv_release());

        // Undervoltage returns during the reset period.
        uv_in = 1'b1; cyc(5); uv_in = 1'b0;
        cyc(P / 2);
        uv_in = 1'b1; cyc(3); uv_in = 1'b0;
        edges_until(1'b1, n);
        check("R8 restart on uv", n, exp_uv_release());

        // Floating strobe: no watchdog resets.
        idle_lows(4 * T, lows);
        check("R6 float no reset", lows, 0);

        // Enable the watchdog and start from a fresh release.
        wdi_float = 1'b0;
        uv_in = 1'b1; cyc(4); uv_in = 1'b0;
        edges_until(1'b1, n);
        check("R2 release before wdog", n, exp_uv_release());
        edges_until(1'b0, n);
        check("R4 high window", n, exp_wd_high());
        check("R10 wdog cause", int'(cause_wdog), 1);
        edges_until(1'b1, n);
        check("R4 wdog pulse length", n, exp_pulse());
        edges_until(1'b0, n);
        check("R5 full window after reset", n, exp_wd_high());

        // Undervoltage during a watchdog pulse keeps the cause.
        uv_in = 1'b1; cyc(2); uv_in = 1'b0;
        check("R10 cause kept", int'(cause_wdog), 1);
        edges_until(1'b1, n);
        check("R8 uv inside wdog pulse", n, exp_uv_release());

        // Random service gaps from the safe range.
        lows = 0;
        for (int k = 0; k < 30; k++) begin
            int gap = int'($urandom_range(1, T - 6));
            int l;
            wdi_in = ~wdi_in;
            idle_lows(gap, l);
            lows += l;
            if (exp_trip(gap)) lows -= l;
        end
        check("R3 random service", lows, 0);

        // Single-cycle strobe pulses.
        lows = 0;
        for (int k = 0; k < 8; k++) begin
            int l;
            wdi_in = ~wdi_in;
            cyc(1);
            wdi_in = ~wdi_in;
            idle_lows(T - 8, l);
            lows += l;
        end
        check("R7 one-cycle pulses", lows, 0);

        // Stop servicing: a timeout must follow.
        edges_until(1'b0, n);
        check("R4 timeout after service stops", int'(n <= T + 4), 1);
        check("R10 cause after timeout", int'(cause_wdog), 1);
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 20000 && !done; i++) @(negedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule